// File: doc/BRIEF.md
# DDR2 Burst Column Sequencer

This block turns one burst request into the column index of every beat of that burst, one index per clock. A request carries a starting column and a 4-bit mode word. The low three bits of the mode word choose how many beats the burst has. The top bit chooses whether the low column bits count upward with wrap-around or are XORed with the beat number. Each output beat has a valid strobe and a flag that marks the final beat.

The mode word and the starting column are captured when a request is accepted. A request that arrives while a burst is running and before its final beat is refused, and the running burst goes on untouched. A request that arrives during the final beat is accepted and joins the running burst with no gap. A request with an unsupported length code is refused and starts nothing. Each refusal raises a one-cycle pulse that gives its cause.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held, `beat_vld`, `beat_last`, `rej_intr` and `rej_mode` are all 0.
- R2: The burst length comes from `mode_word[2:0]`. Code 3'b010 gives 4 beats and code 3'b011 gives 8 beats. `beat_last` is 1 on the final beat only.
- R3: Any other value of `mode_word[2:0]` on an accepted-window request starts no burst. `rej_mode` is then 1 for exactly the cycle after the request edge.
- R4: With `mode_word[3]`=0 and length 4, beat i carries `col[1:0]` = (start[1:0] + i) mod 4.
- R5: With `mode_word[3]`=1, beat i carries start XOR i on the burst field: bits [1:0] for length 4, bits [2:0] for length 8.
- R6: With `mode_word[3]`=0 and length 8, beat i carries `col[2]` = start[2] XOR i[2] and `col[1:0]` = (start[1:0] + i[1:0]) mod 4. The count wraps inside each group of 4 beats.
- R7: Column bits above the burst field are equal to the start column on every beat: bits [COL_W-1:2] for length 4 and bits [COL_W-1:3] for length 8.
- R8: Beat 0 is visible in the cycle after the accepting edge. Later beats follow on consecutive cycles with no gap.
- R9: A request while a burst is running and not on its final beat is refused. `rej_intr` is 1 for the next cycle and the running burst continues unchanged. This applies to every length and has priority over R3.
- R10: A valid request presented while the final beat is visible is accepted. Its beat 0 follows in the next cycle, so `beat_vld` stays 1.
- R11: A change of `mode_word` or `start_col` after the accepting edge has no effect on the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_vld | input | 1 | Burst request strobe |
| start_col | input | COL_W | Starting column of the request |
| mode_word | input | 4 | [2:0] length code, [3] order select |
| beat_vld | output | 1 | A beat is being presented |
| beat_col | output | COL_W | Column index of the current beat |
| beat_last | output | 1 | Current beat is the final one of its burst |
| rej_intr | output | 1 | Previous request refused: burst in progress |
| rej_mode | output | 1 | Previous request refused: invalid length code |

## Verification
Every result is due at a fixed cycle after the request edge. Beat k of an accepted burst is present k+1 cycles after that edge, and a refusal pulse is present in the first cycle after it. The driver changes inputs on falling edges. It queues the expected beats when it issues a request and samples the refusal outputs on the falling edge that follows the request edge. A monitor compares each presented beat, on the falling edge, against the head of the queue. It also reports a missing beat in any cycle where a burst has started but its queue is not yet empty, so a late or gapped burst is caught as well as a wrong index.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  localparam int unsigned MODE_W   = 4;
  localparam int unsigned MAX_BEATS = 8;
  localparam int unsigned IDX_W    = $clog2(MAX_BEATS);

  localparam logic [2:0] LEN_CODE_4 = 3'b010;
  localparam logic [2:0] LEN_CODE_8 = 3'b011;

  typedef struct packed {
    logic valid;  // length code is supported
    logic len8;   // 1: eight beats, 0: four beats
    logic ilv;    // 1: XOR order, 0: wrapping count
  } burst_mode_t;

endpackage

// File: rtl/bcs_rst_sync.sv
module bcs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/bcs_mode_dec.sv
module bcs_mode_dec
  import bcs_pkg::*;
(
  input  logic [MODE_W-1:0] mode_word,
  output burst_mode_t       mode
);

  always_comb begin
    mode.ilv = mode_word[3];
    unique case (mode_word[2:0])
      LEN_CODE_4: begin mode.valid = 1'b1; mode.len8 = 1'b0; end
      LEN_CODE_8: begin mode.valid = 1'b1; mode.len8 = 1'b1; end
      default:    begin mode.valid = 1'b0; mode.len8 = 1'b0; end
    endcase
  end

endmodule

// File: rtl/bcs_order_gen.sv
module bcs_order_gen
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [IDX_W-1:0] beat_idx,
  input  logic             len8,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  logic [1:0] wrap_lo;

  // low pair counts with wrap inside a nibble in sequential mode
  assign wrap_lo = base_col[1:0] + beat_idx[1:0];

  for (genvar g = 0; g < COL_W; g++) begin : g_bit
    if (g < 2) begin : g_lo
      assign col[g] = ilv ? (base_col[g] ^ beat_idx[g]) : wrap_lo[g];
    end else if (g == 2) begin : g_nib
      // nibble select: toggles with beat bit 2 for length 8 in both orders
      assign col[g] = len8 ? (base_col[g] ^ beat_idx[2]) : base_col[g];
    end else begin : g_hi
      assign col[g] = base_col[g];
    end
  end

endmodule

// File: rtl/bcs_beat_ctl.sv
module bcs_beat_ctl
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_vld,
  input  logic [COL_W-1:0] start_col,
  input  burst_mode_t      mode,
  output logic             busy,
  output logic             last_now,
  output logic [IDX_W-1:0] idx,
  output logic [COL_W-1:0] base_col,
  output logic             len8,
  output logic             ilv,
  output logic             rej_intr,
  output logic             rej_mode
);

  localparam logic [IDX_W-1:0] LAST4 = IDX_W'(3);
  localparam logic [IDX_W-1:0] LAST8 = IDX_W'(MAX_BEATS - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [COL_W-1:0] base_q;
  logic             len8_q, ilv_q;
  logic             rej_intr_q, rej_intr_d;
  logic             rej_mode_q, rej_mode_d;
  logic             can_take, accept;

  always_comb begin
    last_now   = busy_q && (idx_q == (len8_q ? LAST8 : LAST4));
    can_take   = !busy_q || last_now;
    accept     = start_vld && can_take && mode.valid;
    rej_intr_d = start_vld && !can_take;
    rej_mode_d = start_vld && can_take && !mode.valid;

    busy_d = busy_q;
    idx_d  = idx_q;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (last_now) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      idx_q      <= '0;
      rej_intr_q <= 1'b0;
      rej_mode_q <= 1'b0;
    end else begin
      busy_q     <= busy_d;
      idx_q      <= idx_d;
      rej_intr_q <= rej_intr_d;
      rej_mode_q <= rej_mode_d;
    end
  end

  // request datapath: loaded only on acceptance, no reset needed
  always_ff @(posedge clk) begin
    if (accept) begin
      base_q <= start_col;
      len8_q <= mode.len8;
      ilv_q  <= mode.ilv;
    end
  end

  assign busy     = busy_q;
  assign idx      = idx_q;
  assign base_col = base_q;
  assign len8     = len8_q;
  assign ilv      = ilv_q;
  assign rej_intr = rej_intr_q;
  assign rej_mode = rej_mode_q;

  // R8
  beat_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_now) |=> busy_q);

  // R2
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(last_now));

  // R9
  intr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej_intr_q |-> busy_q);

  // R3
  mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej_mode_q |-> !busy_q);

  // R11
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_now) |=> ($stable(base_q) && $stable(len8_q) && $stable(ilv_q)));

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_vld,
  input  logic [COL_W-1:0] start_col,
  input  logic [3:0]       mode_word,
  output logic             beat_vld,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last,
  output logic             rej_intr,
  output logic             rej_mode
);

  logic             rst_n_i;
  burst_mode_t      mode;
  logic             busy, last_now, len8, ilv;
  logic [IDX_W-1:0] idx;
  logic [COL_W-1:0] base_col;

  bcs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  bcs_mode_dec u_dec (
    .mode_word (mode_word),
    .mode      (mode)
  );

  bcs_beat_ctl #(.COL_W(COL_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .start_vld (start_vld),
    .start_col (start_col),
    .mode      (mode),
    .busy      (busy),
    .last_now  (last_now),
    .idx       (idx),
    .base_col  (base_col),
    .len8      (len8),
    .ilv       (ilv),
    .rej_intr  (rej_intr),
    .rej_mode  (rej_mode)
  );

  bcs_order_gen #(.COL_W(COL_W)) u_gen (
    .base_col (base_col),
    .beat_idx (idx),
    .len8     (len8),
    .ilv      (ilv),
    .col      (beat_col)
  );

  assign beat_vld  = busy;
  assign beat_last = last_now;

endmodule

// File: tb/burst_col_seq_bench.sv
`timescale 1ns/1ps
module burst_col_seq_bench;

  localparam int COLW = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_vld = 1'b0;
  logic [COLW-1:0] start_col = '0;
  logic [3:0]      mode_word = 4'b0010;
  logic            beat_vld, beat_last, rej_intr, rej_mode;
  logic [COLW-1:0] beat_col;

  burst_col_seq #(.COL_W(COLW)) u_burst_col_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_vld (start_vld),
    .start_col (start_col),
    .mode_word (mode_word),
    .beat_vld  (beat_vld),
    .beat_col  (beat_col),
    .beat_last (beat_last),
    .rej_intr  (rej_intr),
    .rej_mode  (rej_mode)
  );

  always #2 clk = ~clk;

  typedef struct packed {
    logic [COLW-1:0] col;
    logic            last;
  } item_t;

  item_t sbq[$];
  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    armed = 1'b0;
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [COLW-1:0] exp_col(input logic [COLW-1:0] s,
      input bit len8, input bit ilv, input int i);
    logic [2:0] bi;
    logic [2:0] off;
    logic [COLW-1:0] r;
    bi = 3'(i);
    r  = s;
    if (len8) begin
      if (ilv) off = s[2:0] ^ bi;
      else     off = {s[2] ^ bi[2], 2'(s[1:0] + bi[1:0])};
      r[2:0] = off;
    end else begin
      if (ilv) r[1:0] = s[1:0] ^ bi[1:0];
      else     r[1:0] = 2'(s[1:0] + bi[1:0]);
    end
    return r;
  endfunction

  task automatic push_burst(input logic [COLW-1:0] s, input logic [3:0] m);
    bit len8;
    int n;
    item_t it;
    len8 = (m[2:0] == 3'b011);
    n = len8 ? 8 : 4;
    for (int i = 0; i < n; i++) begin
      it.col  = exp_col(s, len8, m[3], i);
      it.last = (i == n - 1);
      sbq.push_back(it);
    end
  endtask

  // monitor: compares every presented beat against the queue head
  always @(negedge clk) begin
    item_t e;
    if (rst_n && !done) begin
      if (beat_vld) begin
        if (sbq.size() == 0) begin
          chk(1'b0, cur_req, "unexpected beat", int'(beat_col), 0);
        end else begin
          e = sbq.pop_front();
          chk(beat_col == e.col, cur_req, "beat column", int'(beat_col), int'(e.col));
          chk(beat_last == e.last, "R2", "beat last flag", int'(beat_last), int'(e.last));
          if (sbq.size() == 0) armed = 1'b0;
        end
      end else if (armed) begin
        chk(1'b0, "R8", "missing beat", 0, 1);
        armed = 1'b0;
      end
    end
  end

  // called at a falling edge; returns at the falling edge after the request edge
  task automatic do_start(input logic [COLW-1:0] col, input logic [3:0] m,
                          input bit acc, input bit e_intr, input bit e_mode);
    start_col = col;
    mode_word = m;
    start_vld = 1'b1;
    if (acc) push_burst(col, m);
    @(posedge clk);
    #1;
    start_vld = 1'b0;
    if (acc) armed = 1'b1;
    @(negedge clk);
    chk(rej_intr == e_intr, "R9", "rej_intr", int'(rej_intr), int'(e_intr));
    chk(rej_mode == e_mode, "R3", "rej_mode", int'(rej_mode), int'(e_mode));
    if (acc) chk(beat_vld == 1'b1, "R8", "beat 0 timing", int'(beat_vld), 1);
  endtask

  task automatic drain();
    repeat (12) @(negedge clk);
    chk(sbq.size() == 0, cur_req, "pending beats", sbq.size(), 0);
    chk(beat_vld == 1'b0, cur_req, "idle after burst", int'(beat_vld), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R8 watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(beat_vld == 1'b0, "R1", "beat_vld in reset", int'(beat_vld), 0);
    chk(beat_last == 1'b0, "R1", "beat_last in reset", int'(beat_last), 0);
    chk(rej_intr == 1'b0 && rej_mode == 1'b0, "R1", "reject pulses in reset",
        int'({rej_intr, rej_mode}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 / R7: length 4 wrapping count, all start offsets, upper bits kept
    cur_req = "R4";
    for (int k = 0; k < 4; k++) begin
      do_start(10'h2A4 | 10'(k), 4'b0010, 1'b1, 1'b0, 1'b0);
      drain();
    end

    // R5: length 4 XOR order
    cur_req = "R5";
    for (int k = 1; k < 4; k++) begin
      do_start(10'h1F0 | 10'(k), 4'b1010, 1'b1, 1'b0, 1'b0);
      drain();
    end

    // R6 / R7: length 8 nibble-wrapping count
    cur_req = "R6";
    do_start(10'h3F8, 4'b0011, 1'b1, 1'b0, 1'b0); drain();
    do_start(10'h3F9, 4'b0011, 1'b1, 1'b0, 1'b0); drain();
    do_start(10'h155, 4'b0011, 1'b1, 1'b0, 1'b0); drain();
    do_start(10'h0AE, 4'b0011, 1'b1, 1'b0, 1'b0); drain();

    // R5 / R7: length 8 XOR order
    cur_req = "R5";
    do_start(10'h2A3, 4'b1011, 1'b1, 1'b0, 1'b0); drain();
    do_start(10'h3FE, 4'b1011, 1'b1, 1'b0, 1'b0); drain();

    // R3: unsupported length codes start nothing
    cur_req = "R3";
    do_start(10'h011, 4'b0000, 1'b0, 1'b0, 1'b1); drain();
    do_start(10'h012, 4'b0111, 1'b0, 1'b0, 1'b1); drain();
    do_start(10'h013, 4'b1001, 1'b0, 1'b0, 1'b1); drain();

    // R9: interruption attempts during a length 8 and a length 4 burst
    cur_req = "R9";
    do_start(10'h301, 4'b0011, 1'b1, 1'b0, 1'b0);
    do_start(10'h0FF, 4'b1010, 1'b0, 1'b1, 1'b0);
    do_start(10'h0FF, 4'b0101, 1'b0, 1'b1, 1'b0);
    drain();
    do_start(10'h122, 4'b0010, 1'b1, 1'b0, 1'b0);
    do_start(10'h200, 4'b0011, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    do_start(10'h200, 4'b0010, 1'b0, 1'b1, 1'b0);
    drain();

    // R10: back-to-back bursts on the final beat
    cur_req = "R10";
    do_start(10'h046, 4'b0010, 1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(beat_last == 1'b1, "R10", "final beat visible", int'(beat_last), 1);
    do_start(10'h38D, 4'b1011, 1'b1, 1'b0, 1'b0);
    chk(beat_vld == 1'b1, "R10", "no gap between bursts", int'(beat_vld), 1);
    repeat (7) @(negedge clk);
    do_start(10'h0C5, 4'b0011, 1'b1, 1'b0, 1'b0);
    drain();

    // R10 / R3: invalid code on the final beat ends the burst cleanly
    do_start(10'h046, 4'b0010, 1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    do_start(10'h046, 4'b0110, 1'b0, 1'b0, 1'b1);
    chk(beat_vld == 1'b0, "R3", "no burst after invalid code", int'(beat_vld), 0);
    drain();

    // R11: inputs changed mid-burst have no effect
    cur_req = "R11";
    do_start(10'h2D7, 4'b0011, 1'b1, 1'b0, 1'b0);
    mode_word = 4'b1010;
    start_col = 10'h000;
    drain();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule